// File: doc/BRIEF.md
# Binary Hit Trigger-Latency Pipeline

This block takes one binary discriminator output per channel and keeps each hit long enough for a late trigger decision. Every channel can invert its input. The input then crosses into the system clock through a chain of flip-flops. A rising-edge detector reduces each hit to a single clock. The hit then travels through a fixed-depth shift pipeline, whose depth equals the trigger latency of the experiment.

When a trigger arrives, a gate opens on the following clock and stays open for a programmed number of clocks. During the gate, each channel's pipeline output is ORed into an accumulator. When the gate closes, the accumulated bits become the latched hit pattern and a valid flag pulses. The pattern then holds its value until the next gate closes. A default instance serves 16 channels with a 100-stage pipeline and a two-flop synchronizer.

Top module: `hit_latency_pipe`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears the synchronizers, the pipeline, the gate and the accumulator, and drives `hit_pattern` to 0 and `hit_valid` to 0. No hit that entered before the reset appears in any later pattern.
- R2: When `polarity[i]` is 1, channel i is inverted before synchronization. A 0-to-1 change of `hit_in[i] ^ polarity[i]` is a hit, so setting `polarity[i]` while `hit_in[i]` is low also produces one hit.
- R3: Each 0-to-1 transition of a channel's adjusted input gives exactly one single-clock hit, however long the level stays high. The later clocks of a long pulse contribute nothing.
- R4: Suppose an adjusted input is first sampled high at clock edge k. It is then presented to the gate logic at edge k + DEPTH + 2 (102 with defaults), which is two synchronizer stages plus DEPTH pipeline stages.
- R5: The gate width code `gate_width` is captured together with the trigger. A code of n gives a gate of n+1 clocks (0 gives 1 clock, 7 gives 8 clocks).
- R6: For a trigger accepted at edge t with width W, a channel's bit is 1 exactly when that channel's pipeline output is 1 at one or more of the edges t+1 through t+W. Hits presented at edge t or at edge t+W+1 are not captured.
- R7: `hit_valid` is high for exactly one clock, in the cycle after edge t+W. `hit_pattern` takes its new value at the same edge.
- R8: `hit_pattern` changes only together with a `hit_valid` pulse, or by reset.
- R9: A trigger sampled while a gate is open (edges t+1 through t+W) has no effect. It neither restarts nor extends the gate, and it does not produce a second valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trigger | input | 1 | Trigger request, sampled at each rising edge |
| gate_width | input | GW_BITS (3) | Gate length code; the gate lasts code+1 clocks |
| polarity | input | NUM_CH (16) | Per-channel inversion, 1 = invert |
| hit_in | input | NUM_CH (16) | Asynchronous binary hit inputs |
| hit_pattern | output | NUM_CH (16) | Latched hit pattern of the last closed gate |
| hit_valid | output | 1 | One-clock pulse when a new pattern is latched |

## Verification
The pipeline output of a channel can rise on the very clock that a trigger is accepted, or on the clock just after the gate closes. In both cases the capture logic must leave that hit out, while it must include a hit arriving one clock later or one clock earlier respectively. Directed shots place single hits at offsets 0, 1, W and W+1 from the trigger, and the latched bit is compared against a value derived by hand. A second collision occurs when a trigger lands inside an open gate. This is provoked with a back-to-back trigger pair, and the bench judges it by counting valid pulses. Long random runs compare every cycle against a bench model that replays the adjusted input history.

// File: rtl/hlp_pkg.sv
package hlp_pkg;

   typedef enum logic {
      GATE_IDLE = 1'b0,
      GATE_OPEN = 1'b1
   } gate_state_e;

   // Number of clocks a gate stays open for a given width code
   function automatic int unsigned gate_clocks(input int unsigned code);
      return code + 1;
   endfunction

endpackage

// File: rtl/hlp_chan_front.sv
module hlp_chan_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_in,
   input  logic invert,
   output logic hit_pulse
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hlp_chan_front: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   adj_in;

   assign adj_in = raw_in ^ invert;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], adj_in};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign hit_pulse = sync_q[SYNC_STAGES-1] & ~last_q;

   AST_HIT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      hit_pulse |=> !hit_pulse)
      else $error("hit pulse lasted more than one clock"); // R3

endmodule

// File: rtl/hlp_delay_line.sv
module hlp_delay_line #(
   parameter int DEPTH = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hlp_delay_line: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (rst) stage_q <= '0;
      else     stage_q <= {stage_q[DEPTH-2:0], din};
   end

   assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/hlp_gate_ctrl.sv
module hlp_gate_ctrl
   import hlp_pkg::*;
#(
   parameter int GW_BITS = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               trig,
   input  logic [GW_BITS-1:0] width_code,
   output logic               gate_en,
   output logic               gate_last,
   output logic               done_pulse
);

   localparam int CNT_W = GW_BITS + 1;

   generate
      if (GW_BITS < 1) begin : g_bad_gw
         $error("hlp_gate_ctrl: GW_BITS must be at least 1");
      end
   endgenerate

   gate_state_e      state_q;
   logic [CNT_W-1:0] left_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= GATE_IDLE;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            GATE_IDLE: begin
               if (trig) begin
                  state_q <= GATE_OPEN;
                  left_q  <= CNT_W'(width_code) + CNT_W'(1);
               end
            end
            GATE_OPEN: begin
               left_q <= left_q - CNT_W'(1);
               if (left_q == CNT_W'(1)) begin
                  state_q <= GATE_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= GATE_IDLE;
         endcase
      end
   end

   assign gate_en    = (state_q == GATE_OPEN);
   assign gate_last  = (state_q == GATE_OPEN) && (left_q == CNT_W'(1));
   assign done_pulse = done_q;

   AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q)
      else $error("valid pulse longer than one clock"); // R7

   AST_GATE_LOAD: assert property (@(posedge clk) disable iff (rst)
      (state_q == GATE_IDLE && trig) |=>
         (state_q == GATE_OPEN && left_q == CNT_W'($past(width_code)) + CNT_W'(1)))
      else $error("gate did not load width code"); // R5

   AST_TRIG_IN_GATE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (state_q == GATE_OPEN && trig && left_q != CNT_W'(1)) |=>
         (state_q == GATE_OPEN && left_q == $past(left_q) - CNT_W'(1)))
      else $error("trigger disturbed an open gate"); // R9

endmodule

// File: rtl/hit_latency_pipe.sv
module hit_latency_pipe
   import hlp_pkg::*;
#(
   parameter int NUM_CH      = 16,
   parameter int DEPTH       = 100,
   parameter int SYNC_STAGES = 2,
   parameter int GW_BITS     = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               trigger,
   input  logic [GW_BITS-1:0] gate_width,
   input  logic [NUM_CH-1:0]  polarity,
   input  logic [NUM_CH-1:0]  hit_in,
   output logic [NUM_CH-1:0]  hit_pattern,
   output logic               hit_valid
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("hit_latency_pipe: NUM_CH must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0] edge_hit;
   logic [NUM_CH-1:0] pipe_out;
   logic [NUM_CH-1:0] acc_q;
   logic [NUM_CH-1:0] pattern_q;
   logic              gate_en;
   logic              gate_last;
   logic              done_pulse;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
         hlp_chan_front #(
            .SYNC_STAGES (SYNC_STAGES)
         ) u_front (
            .clk       (clk),
            .rst       (rst),
            .raw_in    (hit_in[ch]),
            .invert    (polarity[ch]),
            .hit_pulse (edge_hit[ch])
         );

         hlp_delay_line #(
            .DEPTH (DEPTH)
         ) u_delay (
            .clk  (clk),
            .rst  (rst),
            .din  (edge_hit[ch]),
            .dout (pipe_out[ch])
         );
      end
   endgenerate

   hlp_gate_ctrl #(
      .GW_BITS (GW_BITS)
   ) u_gate (
      .clk        (clk),
      .rst        (rst),
      .trig       (trigger),
      .width_code (gate_width),
      .gate_en    (gate_en),
      .gate_last  (gate_last),
      .done_pulse (done_pulse)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q     <= '0;
         pattern_q <= '0;
      end else if (gate_en) begin
         if (gate_last) begin
            pattern_q <= acc_q | pipe_out;
            acc_q     <= '0;
         end else begin
            acc_q <= acc_q | pipe_out;
         end
      end else begin
         acc_q <= '0;
      end
   end

   assign hit_pattern = pattern_q;
   assign hit_valid   = done_pulse;

   AST_PATTERN_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!hit_valid && !$past(rst)) |-> $stable(hit_pattern))
      else $error("pattern changed without valid"); // R8

   AST_ACC_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!gate_en) |=> (!gate_en || acc_q == '0))
      else $error("accumulator not empty at gate start"); // R6

endmodule

// File: tb/tb_hit_latency_pipe.sv
`timescale 1ns/1ps
module tb_hit_latency_pipe;

   localparam int NCH   = 16;
   localparam int DEPTH = 100;
   localparam int GWB   = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst = 1'b1;
   logic           trigger = 1'b0;
   logic [GWB-1:0] gate_width = '0;
   logic [NCH-1:0] polarity = '0;
   logic [NCH-1:0] hit_in = '0;
   logic [NCH-1:0] hit_pattern;
   logic           hit_valid;

   hit_latency_pipe #(
      .NUM_CH (NCH), .DEPTH (DEPTH), .SYNC_STAGES (2), .GW_BITS (GWB)
   ) dut (
      .clk (clk), .rst (rst), .trigger (trigger), .gate_width (gate_width),
      .polarity (polarity), .hit_in (hit_in),
      .hit_pattern (hit_pattern), .hit_valid (hit_valid)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";

   // values to be applied before the next edge
   logic [NCH-1:0] d_hit = '0, d_pol = '0;
   logic           d_trig = 1'b0, d_rst = 1'b1;
   logic [GWB-1:0] d_gw = '0;

   // reference model state
   logic [NCH-1:0] hist [256];
   int             e_idx = 300;
   bit             m_busy = 0;
   int             m_cnt = 0;
   logic [NCH-1:0] m_acc = '0, m_pat = '0;
   logic           m_val = 1'b0;
   bit             m_ready = 0;

   task automatic check_vec(string t, string what, logic [NCH-1:0] got, logic [NCH-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", t, what, got, exp);
      end
   endtask

   task automatic check_int(string t, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s got %0d exp %0d", t, what, got, exp);
      end
   endtask

   function automatic logic [NCH-1:0] pipe_at(int e);
      return hist[(e - DEPTH - 2) & 255] & ~hist[(e - DEPTH - 3) & 255];
   endfunction

   task automatic model_adv();
      logic [NCH-1:0] pipe;
      if (d_rst) begin
         for (int i = 0; i < 256; i++) hist[i] = '0;
         m_busy = 0; m_cnt = 0; m_acc = '0; m_pat = '0; m_val = 1'b0;
      end else begin
         pipe = pipe_at(e_idx);
         hist[e_idx & 255] = d_hit ^ d_pol;
         m_val = 1'b0;
         if (m_busy) begin
            m_acc |= pipe;
            m_cnt--;
            if (m_cnt == 0) begin
               m_pat = m_acc; m_val = 1'b1; m_busy = 0; m_acc = '0;
            end
         end else if (d_trig) begin
            m_busy = 1; m_cnt = int'(d_gw) + 1; m_acc = '0;
         end
      end
      e_idx++;
   endtask

   task automatic step();
      @(negedge clk);
      if (m_ready) begin
         check_vec({tag, " R7"}, "hit_valid", NCH'(hit_valid), NCH'(m_val));
         check_vec({tag, " R8"}, "hit_pattern", hit_pattern, m_pat);
      end
      rst = d_rst; trigger = d_trig; gate_width = d_gw;
      polarity = d_pol; hit_in = d_hit;
      model_adv();
      if (d_rst) m_ready = 1;
   endtask

   // single hit on one channel, trigger placed so the hit is presented at t+offset
   task automatic shot(int ch, bit use_pol, int len, int offset, int wcode, bit expb, string t);
      int n;
      int vcount;
      logic [NCH-1:0] exp_pat;
      tag = t;
      d_trig = 1'b0;
      for (int i = 0; i < 12; i++) step();
      if (use_pol) d_pol[ch] = 1'b1; else d_hit[ch] = 1'b1;
      step();
      n = DEPTH + 1 - offset;
      for (int i = 0; i < n; i++) begin
         if (!use_pol && i == len - 1) d_hit[ch] = 1'b0;
         step();
      end
      d_hit[ch] = 1'b0;
      d_trig = 1'b1; d_gw = GWB'(wcode);
      step();
      d_trig = 1'b0;
      vcount = 0;
      for (int i = 0; i < wcode + 3; i++) begin
         step();
         vcount += int'(hit_valid);
      end
      exp_pat = expb ? (NCH'(1) << ch) : '0;
      check_int(t, "valid pulse count", vcount, 1);
      check_vec(t, "latched pattern", hit_pattern, exp_pat);
      d_pol[ch] = 1'b0;
   endtask

   initial begin : main
      int vcount;
      void'($urandom(32'd4242));
      // R1: reset state
      tag = "R1";
      d_rst = 1'b1;
      for (int i = 0; i < 4; i++) step();
      d_rst = 1'b0;
      step();
      check_vec("R1", "pattern after reset", hit_pattern, '0);
      check_int("R1", "valid after reset", int'(hit_valid), 0);

      // window boundaries and latency
      shot(0, 0, 3, 0, 0, 0, "R6");   // presented on trigger edge: excluded
      shot(1, 0, 3, 1, 0, 1, "R4");   // first gate edge: captured
      shot(2, 0, 3, 8, 7, 1, "R5");   // last edge of an 8-clock gate
      shot(3, 0, 3, 9, 7, 0, "R6");   // one past the gate
      shot(4, 0, 3, 4, 2, 0, "R5");   // 3-clock gate misses offset 4
      shot(9, 0, 3, 3, 2, 1, "R5");   // 3-clock gate catches offset 3
      shot(5, 1, 0, 2, 1, 1, "R2");   // polarity flip alone makes a hit
      shot(6, 0, 40, -5, 7, 0, "R3"); // body of a long pulse is not a hit
      shot(7, 0, 40, 1, 7, 1, "R3");  // leading edge of a long pulse is

      // R9: second trigger inside an open gate
      tag = "R9";
      for (int i = 0; i < 12; i++) step();
      d_trig = 1'b1; d_gw = 3'd7; step();
      d_trig = 1'b0;
      vcount = 0;
      for (int i = 0; i < 3; i++) begin step(); vcount += int'(hit_valid); end
      d_trig = 1'b1; d_gw = 3'd0; step();
      d_trig = 1'b0;
      vcount += int'(hit_valid);
      for (int i = 0; i < 14; i++) begin step(); vcount += int'(hit_valid); end
      check_int("R9", "valid pulses for trigger pair", vcount, 1);

      // random traffic
      for (int r = 0; r < 2; r++) begin
         tag = "R6";
         for (int i = 0; i < 2500; i++) begin
            d_hit  = d_hit ^ (NCH'($urandom) & NCH'($urandom) & NCH'($urandom));
            if ($urandom_range(199) == 0) d_pol = NCH'($urandom);
            d_trig = ($urandom_range(11) == 0);
            d_gw   = GWB'($urandom);
            step();
         end
         // R1: mid-run reset drops hits still in the pipeline
         tag = "R1";
         d_trig = 1'b0; d_hit = '0; d_pol = '0;
         d_rst = 1'b1; step(); step();
         d_rst = 1'b0; step();
         check_vec("R1", "pattern after mid-run reset", hit_pattern, '0);
         d_trig = 1'b1; d_gw = 3'd7; step();
         d_trig = 1'b0;
         for (int i = 0; i < 12; i++) step();
         check_vec("R1", "pattern from flushed pipeline", hit_pattern, '0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog cycles got 100000 exp fewer");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule